// File: doc/BRIEF.md
# Serial ADC Conversion Read Controller

This block is an SPI master that runs one conversion read on a 12-bit serial successive-approximation converter. A user request carries a 3-bit channel number and a single-ended/differential select. The block lowers an active-low chip select and clocks out a command header. It then samples the converter's reply and returns the 12-bit result with a one-cycle done pulse. SCK is derived from the system clock. Each SCK half period lasts a parameterised number of system clocks, so the integrator can keep SCK at or below the converter's 2 MHz limit.

The serial clock idles low. The master changes MOSI only while SCK is low, and it samples MISO on every rising edge. The header is a start bit of 1, then the mode bit, then the channel number MSB first. After the header the converter leaves its output undriven for one sample and sends a null 0. It then sends the result MSB first. A frame-select input picks one of two framings. The compact framing uses 19 clocks. The byte-aligned framing adds five leading zero bits to make 24 clocks, which right-justifies the result in three bytes. In both framings the result is the last twelve bits sampled.

Top module: `adc_read_ctrl`

## Requirements
- R1: After reset, chipSelN is 1, sck is 0, busy is 0, done is 0 and result is 0.
- R2: The first 1 on mosi at a rising sck edge is the start bit. The next rising edge carries reqSingle (1 = single-ended). The three after that carry reqChan bit 2, bit 1, then bit 0.
- R3: With frameMode = 0 (compact), a conversion has exactly 19 rising sck edges and no zero bits before the start bit.
- R4: With frameMode = 1 (byte-aligned), a conversion has exactly 24 rising sck edges, and mosi is 0 on the five rising edges before the start bit.
- R5: miso is sampled on rising sck edges. result holds the last 12 bits sampled in the frame, with the first of them as bit 11.
- R6: Every sck high phase and every sck low phase inside a frame lasts HALF_DIV system clocks. sck is 0 whenever chipSelN is 1.
- R7: chipSelN falls HALF_DIV system clocks before the first rising sck edge. It rises HALF_DIV system clocks after the last falling sck edge.
- R8: done is high for exactly one system clock, in the cycle where chipSelN has just returned high. result changes only at that point and holds its value until the next completed conversion.
- R9: busy is high from the cycle after a request is accepted until done. A request made while busy is ignored: the running frame keeps its header and length, and no second frame starts.
- R10: mosi does not change while sck stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Conversion request, accepted when busy is low |
| reqChan | input | 3 | Channel number to convert |
| reqSingle | input | 1 | 1 = single-ended, 0 = differential |
| frameMode | input | 1 | 0 = compact 19-clock frame, 1 = byte-aligned 24-clock frame |
| busy | output | 1 | Conversion in progress |
| chipSelN | output | 1 | Active-low converter select |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to converter |
| miso | input | 1 | Serial data from converter |
| result | output | 12 | Last completed conversion value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with HALF_DIV = 3, which gives a six-clock SCK period. A full frame then fits in under 160 system clocks, so every combination of channel, mode bit and framing can be swept exhaustively. All-ones, all-zeros and single-bit result patterns are added on top of the sweep. A behavioural converter model decodes the header and counts rising edges and leading zeros. It places the null bit and the result at the positions the protocol sets. A clock-level monitor times every SCK phase and the chip-select setup and hold windows against HALF_DIV. The short period also leaves room to inject requests in the middle of a frame.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_TAIL
  } rdState_t;

  typedef struct packed {
    logic load;     // capture request fields into the shift path
    logic sample;   // rising SCK edge: take miso
    logic shiftTx;  // falling SCK edge: present next mosi bit
    logic commit;   // frame finished: publish result
  } strobe_t;

endpackage

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl #(
  parameter int HALF_DIV    = 25,
  parameter int COMPACT_LEN = 19,
  parameter int PADDED_LEN  = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                frameMode,
  output logic                busy,
  output logic                chipSelN,
  output logic                sck,
  output logic                done,
  output adcrd_pkg::strobe_t  stb
);
  import adcrd_pkg::*;

  localparam int HC_W = $clog2(HALF_DIV + 1);
  localparam int BC_W = $clog2(PADDED_LEN + 1);
  localparam logic [HC_W-1:0] HC_LAST   = HC_W'(HALF_DIV - 1);
  localparam logic [BC_W-1:0] LAST_CMP  = BC_W'(COMPACT_LEN - 1);
  localparam logic [BC_W-1:0] LAST_PAD  = BC_W'(PADDED_LEN - 1);

  rdState_t        state;
  logic [HC_W-1:0] halfCnt;
  logic [BC_W-1:0] bitCnt;
  logic [BC_W-1:0] lastBit;
  logic            modeLat;
  logic            tick;
  logic            accept;

  assign tick    = (halfCnt == HC_LAST);
  assign accept  = reqValid && (state == ST_IDLE);
  assign lastBit = modeLat ? LAST_PAD : LAST_CMP;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    stb         = '0;
    stb.load    = accept;
    stb.sample  = tick && ((state == ST_SETUP) || (state == ST_LOW));
    stb.shiftTx = tick && (state == ST_HIGH);
    stb.commit  = tick && (state == ST_TAIL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      halfCnt  <= '0;
      bitCnt   <= '0;
      modeLat  <= 1'b0;
      chipSelN <= 1'b1;
      sck      <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE || tick) halfCnt <= '0;
      else                          halfCnt <= halfCnt + 1'b1;
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_SETUP;
          chipSelN <= 1'b0;
          modeLat  <= frameMode;
          bitCnt   <= '0;
        end
        ST_SETUP: if (tick) begin
          sck   <= 1'b1;
          state <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sck <= 1'b0;
          if (bitCnt == lastBit) state <= ST_TAIL;
          else begin
            bitCnt <= bitCnt + 1'b1;
            state  <= ST_LOW;
          end
        end
        ST_LOW: if (tick) begin
          sck   <= 1'b1;
          state <= ST_HIGH;
        end
        ST_TAIL: if (tick) begin
          chipSelN <= 1'b1;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    chipSelN |-> !sck); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_AT_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (chipSelN && !$past(chipSelN))); // R8
  AST_BIT_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitCnt <= lastBit)); // R3
  AST_HALF_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    halfCnt <= HC_LAST); // R6

endmodule

// File: rtl/adcrd_dpath.sv
module adcrd_dpath #(
  parameter int CH_W       = 3,
  parameter int RES_W      = 12,
  parameter int PADDED_LEN = 24,
  parameter int LEAD_ZEROS = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  adcrd_pkg::strobe_t stb,
  input  logic [CH_W-1:0]    reqChan,
  input  logic               reqSingle,
  input  logic               frameMode,
  input  logic               miso,
  output logic               mosi,
  output logic [RES_W-1:0]   result
);
  localparam int HDR_W = 2 + CH_W;

  logic [PADDED_LEN-1:0] txReg;
  logic [PADDED_LEN-1:0] txFrame;
  logic [HDR_W-1:0]      header;
  logic [RES_W-1:0]      rxReg;

  assign header  = {1'b1, reqSingle, reqChan};
  assign txFrame = {header, {(PADDED_LEN - HDR_W){1'b0}}};
  assign mosi    = txReg[PADDED_LEN-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg  <= '0;
      rxReg  <= '0;
      result <= '0;
    end else begin
      if (stb.load)
        txReg <= frameMode ? (txFrame >> LEAD_ZEROS) : txFrame;
      else if (stb.shiftTx)
        txReg <= txReg << 1;
      if (stb.sample) rxReg  <= {rxReg[RES_W-2:0], miso};
      if (stb.commit) result <= rxReg;
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(result)); // R8

endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl #(
  parameter int HALF_DIV = 25,
  parameter int CH_W     = 3,
  parameter int RES_W    = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CH_W-1:0]  reqChan,
  input  logic             reqSingle,
  input  logic             frameMode,
  output logic             busy,
  output logic             chipSelN,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [RES_W-1:0] result,
  output logic             done
);
  localparam int HDR_W       = 2 + CH_W;
  localparam int COMPACT_LEN = HDR_W + 2 + RES_W;
  localparam int PADDED_LEN  = ((COMPACT_LEN + 7) / 8) * 8;
  localparam int LEAD_ZEROS  = PADDED_LEN - COMPACT_LEN;

  adcrd_pkg::strobe_t stb;

  adcrd_ctrl #(
    .HALF_DIV(HALF_DIV), .COMPACT_LEN(COMPACT_LEN), .PADDED_LEN(PADDED_LEN)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .frameMode(frameMode),
    .busy(busy), .chipSelN(chipSelN), .sck(sck), .done(done), .stb(stb)
  );

  adcrd_dpath #(
    .CH_W(CH_W), .RES_W(RES_W), .PADDED_LEN(PADDED_LEN), .LEAD_ZEROS(LEAD_ZEROS)
  ) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqChan(reqChan), .reqSingle(reqSingle),
    .frameMode(frameMode), .miso(miso), .mosi(mosi), .result(result)
  );

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi)); // R10

endmodule

// File: tb/tb_adc_read_ctrl.sv
module tb_adc_read_ctrl;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqChan = '0;
  logic reqSingle = 1'b0;
  logic frameMode = 1'b0;
  logic miso = 1'b1;
  logic busy, chipSelN, sck, mosi, done;
  logic [11:0] result;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  adc_read_ctrl #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan),
    .reqSingle(reqSingle), .frameMode(frameMode), .busy(busy),
    .chipSelN(chipSelN), .sck(sck), .mosi(mosi), .miso(miso),
    .result(result), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural converter model
  logic [11:0] modelVal = '0;
  int riseCnt = 0, leadZeros = 0, k = 0;
  bit started = 0;
  logic capSingle = 1'b0;
  logic [2:0] capChan = '0;

  always @(negedge chipSelN) begin
    riseCnt = 0; leadZeros = 0; k = 0; started = 0; miso = 1'b1;
  end

  always @(posedge sck) if (!chipSelN) begin
    riseCnt++;
    if (!started) begin
      if (mosi) begin started = 1; k = 1; end
      else leadZeros++;
    end else begin
      k++;
      if (k == 2) capSingle = mosi;
      else if (k <= 5) capChan = {capChan[1:0], mosi};
    end
  end

  always @(negedge sck) if (!chipSelN && started) begin
    int n;
    n = k + 1;
    if (n == 7) miso = 1'b0;
    else if (n >= 8 && n <= 19) miso = modelVal[19 - n];
    else miso = 1'b1;
  end

  // clock-level monitor
  int runLen = 0, widthErr = 0, idleErr = 0, mosiErr = 0, doneLong = 0;
  logic pSck = 1'b0, pCs = 1'b1, pMosi = 1'b0, pDone = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (chipSelN && sck) idleErr++;
      if (sck && pSck && (mosi !== pMosi)) mosiErr++;
      if (done && pDone) doneLong++;
      if (!chipSelN && pCs) runLen = 1;
      else if ((sck != pSck) || (chipSelN && !pCs)) begin
        if (runLen != HALF) widthErr++;
        runLen = 1;
      end else runLen++;
    end
    pSck = sck; pCs = chipSelN; pMosi = mosi; pDone = done;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic runConv(input logic [2:0] ch, input logic sgl, input logic md,
                         input logic [11:0] val, input bit interrupt);
    int waitCnt;
    @(negedge clk);
    modelVal = val; reqChan = ch; reqSingle = sgl; frameMode = md; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    if (interrupt) begin
      repeat (40) @(negedge clk);
      reqChan = ~ch; reqSingle = ~sgl; frameMode = ~md; reqValid = 1'b1;
      repeat (2) @(negedge clk);
      reqValid = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 2000) begin
      @(negedge clk);
      waitCnt++;
    end
    chk(done == 1'b1, "R8 done seen", done, 1);
    chk(chipSelN == 1'b1, "R8 deselect with done", chipSelN, 1);
    chk(result == val, "R5 result", result, val);
    chk(capSingle == sgl, "R2 mode bit", capSingle, sgl);
    chk(capChan == ch, "R2 channel", capChan, ch);
    if (md) begin
      chk(riseCnt == 24, "R4 edge count", riseCnt, 24);
      chk(leadZeros == 5, "R4 leading zeros", leadZeros, 5);
    end else begin
      chk(riseCnt == 19, "R3 edge count", riseCnt, 19);
      chk(leadZeros == 0, "R3 leading zeros", leadZeros, 0);
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 idle after done", {busy, done}, 0);
    if (interrupt) begin
      repeat (20) @(negedge clk);
      chk(chipSelN == 1'b1, "R9 no second frame", chipSelN, 1);
      chk(result == val, "R8 result held", result, val);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(chipSelN == 1'b1 && sck == 1'b0, "R1 reset lines", {chipSelN, sck}, 2);
    chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", {busy, done}, 0);
    chk(result == 12'd0, "R1 reset result", result, 0);
    rstN = 1'b1;
    for (int md = 0; md < 2; md++)
      for (int sg = 0; sg < 2; sg++)
        for (int ch = 0; ch < 8; ch++)
          runConv(3'(ch), sg[0], md[0],
                  12'((ch * 517 + sg * 1234 + md * 77 + 1445) & 12'hFFF), 1'b0);
    runConv(3'd7, 1'b1, 1'b0, 12'hFFF, 1'b0);
    runConv(3'd0, 1'b0, 1'b1, 12'h000, 1'b0);
    runConv(3'd5, 1'b1, 1'b1, 12'h800, 1'b0);
    runConv(3'd2, 1'b0, 1'b0, 12'h001, 1'b0);
    runConv(3'd3, 1'b1, 1'b0, 12'hA5C, 1'b1);
    runConv(3'd6, 1'b0, 1'b1, 12'h3C7, 1'b1);
    chk(widthErr == 0, "R6 R7 phase widths", widthErr, 0);
    chk(idleErr == 0, "R6 sck idle low", idleErr, 0);
    chk(mosiErr == 0, "R10 mosi stable high", mosiErr, 0);
    chk(doneLong == 0, "R8 done width", doneLong, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule